// File: doc/BRIEF.md
# UART status flag controller

This block keeps the status flags of a byte-oriented UART and presents them as one readable 8-bit status word. On the receive side it takes per-character events from the receive shifter: the character is complete, its parity check failed, its stop bit was missing, or the whole frame was zero. It also holds the received byte in a receive data register, and it takes a host read strobe for that register. On the transmit side it owns a one-byte holding register. The host fills the register with a write strobe. The block hands the byte to the transmit shifter once that shifter reports idle.

Two small state machines carry the design. The receive machine has the states RX_EMPTY (no unread byte) and RX_FULL (data available). Its transitions are: fill (RX_EMPTY to RX_FULL on a completed character), drain (RX_FULL to RX_EMPTY on a host read with no character completing in the same cycle), and refill (RX_FULL to RX_FULL when a character completes). The transmit machine has the states TX_EMPTY (holding register free) and TX_HELD (holding register occupied). Its transitions are: accept (TX_EMPTY to TX_HELD on a host write), hand-off (TX_HELD to TX_EMPTY when the shifter is idle and no write arrives), and hand-off-and-refill (TX_HELD to TX_HELD when the shifter is idle and a write arrives in the same cycle). The error flags are registers beside the receive machine. The transmitter-empty and clear-to-send bits are combinational.

Top module: `uart_status_ctl`

## Requirements
- R1: After reset the data-available, overrun, parity, framing and break flags are 0, and the holding-empty and transmitter-empty flags are 1 (with the shifter idle).
- R2: A completed character loads its byte into the receive data register and sets data-available on the next cycle. A host read with no character completing in the same cycle clears data-available.
- R3: When a character completes while data-available is 1 and no read occurs in that cycle, overrun is set. The new byte overwrites the receive data register and data-available stays 1.
- R4: A host read clears overrun only when no character completes in the same cycle, so that data-available is 0 after the read. Otherwise overrun keeps its value.
- R5: A completed character with a missing stop bit sets the framing flag. Any host read of the receive data register clears it.
- R6: A completed character flagged as all-zero (data, parity and stop bits) sets the break flag. A host read clears it.
- R7: The parity flag equals the parity-failure input of the most recent completed character. Host reads do not change it.
- R8: When a set event and a clearing read occur in the same cycle, the flag ends up set.
- R9: A host write loads the holding register and clears holding-empty on the next cycle.
- R10: While the holding register is occupied and the shifter is idle, the block pulses the shifter load output in the same cycle, with the held byte on the shifter data output. Holding-empty is 1 on the next cycle unless a write arrives in that same cycle.
- R11: Transmitter-empty is 1 exactly when holding-empty is 1 and the shifter reports idle.
- R12: The clear-to-send status bit shows the live level of the active-low clear-to-send input, with no register in the path.
- R13: Status word layout: bit 0 holding-empty, bit 1 transmitter-empty, bit 2 data-available, bit 3 overrun, bit 4 parity, bit 5 framing, bit 6 break, bit 7 clear-to-send input level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 1 | Receive shifter finished a character this cycle |
| rx_byte | input | 8 | Byte of the finished character |
| rx_par_bad | input | 1 | Finished character failed its parity check |
| rx_stop_bad | input | 1 | Finished character had no valid stop bit |
| rx_all_zero | input | 1 | Data, parity and stop bits of the finished character were all 0 |
| host_rd | input | 1 | Host reads the receive data register |
| host_rdata | output | 8 | Receive data register contents |
| host_wr | input | 1 | Host writes the transmit holding register |
| host_wdata | input | 8 | Byte written by the host |
| sh_idle | input | 1 | Transmit shifter is idle, with nothing being sent |
| sh_load | output | 1 | Hand the held byte to the transmit shifter |
| sh_data | output | 8 | Byte handed to the transmit shifter |
| cts_n | input | 1 | Clear-to-send input, active low |
| stat | output | 8 | Status word, with the layout given in R13 |

## Verification
The receive sweep starts from three states: empty, one unread byte, and an unread byte with overrun and every error flag set. From each state it applies every combination of character completion, read, stop fault, zero frame and parity fault, and compares the result with a flag equation worked out from the requirements. This sweep exposes four kinds of fault. A design that clears overrun on any read is caught when the read coincides with a new character. A design that lets a read win over a set event loses a framing or break flag. A design that raises overrun when the old byte is read in the same cycle is also caught, and so is one that clears the parity flag on a read. A second sweep covers every transmit combination of occupied holding register, write and shifter idle. It catches a design that drops a byte written during the hand-off cycle. It also catches a design that reports transmitter-empty while the shifter is still sending.

// File: rtl/uart_stat_pkg.sv
package uart_stat_pkg;
    typedef enum logic { RX_EMPTY = 1'b0, RX_FULL = 1'b1 } rx_state_t;
    typedef enum logic { TX_EMPTY = 1'b0, TX_HELD = 1'b1 } tx_state_t;

    // Status word layout (R13)
    localparam int STAT_W     = 8;
    localparam int POS_TDRE   = 0;
    localparam int POS_TXE    = 1;
    localparam int POS_AVAIL  = 2;
    localparam int POS_OVR    = 3;
    localparam int POS_PAR    = 4;
    localparam int POS_FRM    = 5;
    localparam int POS_BRK    = 6;
    localparam int POS_CTS    = 7;
endpackage

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
    import uart_stat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] din,
    input  logic          par_bad,
    input  logic          stop_bad,
    input  logic          all_zero,
    input  logic          rd,
    output logic [DW-1:0] rdata,
    output logic          avail,
    output logic          ovr,
    output logic          par,
    output logic          frm,
    output logic          brk
);
    rx_state_t state_q, state_d;
    logic [DW-1:0] data_q;
    logic ovr_q, par_q, frm_q, brk_q;
    logic set_ovr, clr_ovr;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    // next state: fill, drain, refill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (done)       state_d = RX_FULL;
            RX_FULL:  if (rd && !done) state_d = RX_EMPTY;
            default:  state_d = RX_EMPTY;
        endcase
    end

    assign set_ovr = done && (state_q == RX_FULL) && !rd;
    assign clr_ovr = rd && !done;

    // flag and data registers; set events win over clearing reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            ovr_q  <= 1'b0;
            par_q  <= 1'b0;
            frm_q  <= 1'b0;
            brk_q  <= 1'b0;
        end else begin
            if (done) begin
                data_q <= din;
                par_q  <= par_bad;
            end
            ovr_q <= set_ovr || (ovr_q && !clr_ovr);
            frm_q <= (done && stop_bad) || (frm_q && !rd);
            brk_q <= (done && all_zero) || (brk_q && !rd);
        end
    end

    // outputs
    always_comb begin
        rdata = data_q;
        avail = (state_q == RX_FULL);
        ovr   = ovr_q;
        par   = par_q;
        frm   = frm_q;
        brk   = brk_q;
    end

    // R2
    fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (avail && rdata == $past(din)));
    // R3
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && avail && !rd) |=> ovr);
    // R4
    ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(rd && !done)) |=> ovr);
    // R5
    frm_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && !(done && stop_bad)) |=> !frm);
    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && all_zero && rd) |=> brk);
    // R7
    par_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(par));
endmodule

// File: rtl/uart_tx_hold.sv
module uart_tx_hold
    import uart_stat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          sh_idle,
    output logic          sh_load,
    output logic [DW-1:0] sh_data,
    output logic          tdre,
    output logic          txe
);
    tx_state_t state_q, state_d;
    logic [DW-1:0] hold_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TX_EMPTY;
        else        state_q <= state_d;
    end

    // next state: accept, hand-off, hand-off-and-refill
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_EMPTY: if (wr)              state_d = TX_HELD;
            TX_HELD:  if (sh_idle && !wr)  state_d = TX_EMPTY;
            default:  state_d = TX_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  hold_q <= '0;
        else if (wr) hold_q <= wdata;
    end

    // outputs
    always_comb begin
        sh_load = (state_q == TX_HELD) && sh_idle;
        sh_data = hold_q;
        tdre    = (state_q == TX_EMPTY);
        txe     = tdre && sh_idle;
    end

    // R9
    wr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !tdre);
    // R10
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_load && !wr) |=> tdre);
    // R10
    load_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_load |-> !tdre);
    // R11
    txe_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        txe |-> sh_idle);
endmodule

// File: rtl/uart_status_ctl.sv
module uart_status_ctl
    import uart_stat_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rx_par_bad,
    input  logic          rx_stop_bad,
    input  logic          rx_all_zero,
    input  logic          host_rd,
    output logic [DW-1:0] host_rdata,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          sh_idle,
    output logic          sh_load,
    output logic [DW-1:0] sh_data,
    input  logic          cts_n,
    output logic [STAT_W-1:0] stat
);
    logic avail, ovr, par, frm, brk, tdre, txe;

    uart_rx_flags #(.DW(DW)) u_rx (
        .clk(clk), .rst_n(rst_n), .done(rx_done), .din(rx_byte),
        .par_bad(rx_par_bad), .stop_bad(rx_stop_bad), .all_zero(rx_all_zero),
        .rd(host_rd), .rdata(host_rdata), .avail(avail), .ovr(ovr),
        .par(par), .frm(frm), .brk(brk)
    );

    uart_tx_hold #(.DW(DW)) u_tx (
        .clk(clk), .rst_n(rst_n), .wr(host_wr), .wdata(host_wdata),
        .sh_idle(sh_idle), .sh_load(sh_load), .sh_data(sh_data),
        .tdre(tdre), .txe(txe)
    );

    always_comb begin
        stat            = '0;
        stat[POS_TDRE]  = tdre;
        stat[POS_TXE]   = txe;
        stat[POS_AVAIL] = avail;
        stat[POS_OVR]   = ovr;
        stat[POS_PAR]   = par;
        stat[POS_FRM]   = frm;
        stat[POS_BRK]   = brk;
        stat[POS_CTS]   = cts_n;
    end

    // R12
    cts_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat[POS_CTS] == cts_n);
endmodule

// File: tb/tb_uart_status_ctl.sv
module tb_uart_status_ctl;
    logic clk = 1'b0;
    logic rst_n;
    logic rx_done, rx_par_bad, rx_stop_bad, rx_all_zero, host_rd, host_wr, sh_idle, cts_n;
    logic [7:0] rx_byte, host_wdata, host_rdata, sh_data, stat;
    logic sh_load;
    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    uart_status_ctl dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_par_bad(rx_par_bad), .rx_stop_bad(rx_stop_bad), .rx_all_zero(rx_all_zero),
        .host_rd(host_rd), .host_rdata(host_rdata), .host_wr(host_wr),
        .host_wdata(host_wdata), .sh_idle(sh_idle), .sh_load(sh_load),
        .sh_data(sh_data), .cts_n(cts_n), .stat(stat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic quiet();
        rx_done = 0; rx_par_bad = 0; rx_stop_bad = 0; rx_all_zero = 0;
        host_rd = 0; host_wr = 0; rx_byte = 8'h00; host_wdata = 8'h00;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        quiet();
        sh_idle = 1; cts_n = 1;
        rst_n = 0;
        repeat (2) cyc();
        rst_n = 1;
    endtask

    task automatic rx_char(input logic [7:0] b, input logic p, input logic s, input logic z);
        rx_done = 1; rx_byte = b; rx_par_bad = p; rx_stop_bad = s; rx_all_zero = z;
        cyc();
        quiet();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        logic e_av, e_ov, e_pa, e_fr, e_bk;
        logic [7:0] e_data;
        do_reset();
        @(negedge clk);
        // R1 reset state, R13 layout
        chk("R1 reset status", {24'h0, stat[6:0]}, 32'h03);
        chk("R1 reset data", {24'h0, host_rdata}, 32'h0);

        // R12 live CTS level in bit 7
        cts_n = 0; #1;
        chk("R12 cts low", {31'h0, stat[7]}, 32'h0);
        cts_n = 1; #1;
        chk("R12 cts high", {31'h0, stat[7]}, 32'h1);

        // receive sweep: R2/R3/R4/R5/R6/R7/R8 with R13 bit positions
        for (int pre = 0; pre < 3; pre++) begin
            for (int v = 0; v < 32; v++) begin
                logic d, r, s, z, p;
                logic [7:0] b;
                d = v[0]; r = v[1]; s = v[2]; z = v[3]; p = v[4];
                do_reset();
                e_av = 0; e_ov = 0; e_pa = 0; e_fr = 0; e_bk = 0; e_data = 8'h00;
                if (pre >= 1) begin
                    rx_char(8'h11, 0, 0, 0);
                    e_av = 1; e_data = 8'h11;
                end
                if (pre == 2) begin
                    rx_char(8'h22, 1, 1, 1);
                    e_ov = 1; e_pa = 1; e_fr = 1; e_bk = 1; e_data = 8'h22;
                end
                b = 8'(v * 7 + pre * 64 + 3);
                rx_done = d; host_rd = r; rx_stop_bad = s; rx_all_zero = z;
                rx_par_bad = p; rx_byte = b;
                cyc();
                quiet();
                e_ov = (d & e_av & ~r) | (e_ov & ~(r & ~d));
                e_av = d | (e_av & ~r);
                e_fr = (d & s) | (e_fr & ~r);
                e_bk = (d & z) | (e_bk & ~r);
                if (d) begin e_pa = p; e_data = b; end
                chk($sformatf("R2/R3/R4/R5/R6/R7/R8/R13 rx pre=%0d v=%0d", pre, v),
                    {27'h0, stat[6:2]}, {27'h0, e_bk, e_fr, e_pa, e_ov, e_av});
                chk($sformatf("R2/R3 rx data pre=%0d v=%0d", pre, v),
                    {24'h0, host_rdata}, {24'h0, e_data});
            end
        end

        // transmit sweep: R9/R10/R11
        for (int h = 0; h < 2; h++) begin
            for (int w = 0; w < 2; w++) begin
                for (int i = 0; i < 2; i++) begin
                    logic held_n, e_tdre;
                    do_reset();
                    sh_idle = 0;
                    if (h == 1) begin
                        host_wr = 1; host_wdata = 8'hA5;
                        cyc();
                        quiet();
                        chk("R9 write clears holding-empty", {31'h0, stat[0]}, 32'h0);
                        chk("R11 busy gives transmitter-empty 0", {31'h0, stat[1]}, 32'h0);
                    end
                    sh_idle = i[0]; host_wr = w[0]; host_wdata = 8'h3C; #1;
                    chk($sformatf("R10 load pulse h=%0d w=%0d i=%0d", h, w, i),
                        {31'h0, sh_load}, {31'h0, (h[0] & i[0])});
                    if (h == 1 && i == 1)
                        chk("R10 load data", {24'h0, sh_data}, 32'hA5);
                    cyc();
                    quiet();
                    held_n = w[0] | (h[0] & ~i[0]);
                    e_tdre = ~held_n;
                    chk($sformatf("R9/R10 holding-empty h=%0d w=%0d i=%0d", h, w, i),
                        {31'h0, stat[0]}, {31'h0, e_tdre});
                    chk($sformatf("R11 transmitter-empty h=%0d w=%0d i=%0d", h, w, i),
                        {31'h0, stat[1]}, {31'h0, (e_tdre & i[0])});
                end
            end
        end

        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule